// File: doc/BRIEF.md
# AXI4 Address-Channel Burst Rule Monitor

This block sits beside one AXI4 address channel, either the write-address or the read-address channel, and judges each request's burst attributes against the protocol's legality rules. It is a passive observer. It drives nothing onto the channel and never stalls or alters traffic. In any cycle where the request's VALID is high, it evaluates the address, length, size, burst type, lock bit and cache field. Any rule that fails sets its own sticky flag at that clock edge.

The channel follows the usual valid/ready rules. A request is presented while `req_valid` is high and completes in a cycle where `req_ready` is also high. The monitor applies no back-pressure, because READY is an input only. It evaluates every cycle that VALID is high, so a stalled request is checked again on each cycle of its stall. Each flag stays set until reset. A single combined error output reports that at least one flag is set. The data bus width is a parameter, and the largest legal transfer size is derived from it.

Top module: `axi_burst_rule_monitor`

## Requirements
- R1: After reset, all ten bits of `rule_flags` are 0 and `any_error` is 0.
- R2: Bit 0 (page cross) sets when an INCR burst (`req_burst`=01) covers bytes from start address to start + (LEN+1)*2^SIZE - 1 that lie in different 4096-byte pages. FIXED (00) and WRAP (10) bursts never set bit 0.
- R3: Bit 1 (wrap misalign) sets when a WRAP burst's start address is not a multiple of 2^SIZE.
- R4: Bit 2 (wrap length) sets when a WRAP burst's beat count (LEN+1) is not 2, 4, 8 or 16.
- R5: Bit 3 (reserved type) sets when `req_burst` is 11.
- R6: Bit 4 (fixed length) sets when a FIXED burst has more than 16 beats (LEN > 15).
- R7: Bit 5 (exclusive length) sets when `req_lock` is 1 and the burst has more than 16 beats.
- R8: Bit 6 (exclusive bytes) sets when `req_lock` is 1 and the total byte count (LEN+1)*2^SIZE is either not a power of two or above 128.
- R9: Bit 7 (exclusive misalign) sets when `req_lock` is 1, the total byte count is a power of two, and the start address is not a multiple of that count.
- R10: Bit 8 (oversize) sets when 2^SIZE exceeds DATA_W/8 bytes.
- R11: Bit 9 (reserved cache) sets when `req_cache[1]` is 0 and `req_cache[3:2]` is not 00.
- R12: A flag sets on the rising edge where `req_valid` is high, whatever the value of `req_ready`. It is visible after that edge and stays set until reset. Attributes presented while `req_valid` is low set nothing.
- R13: `any_error` is high exactly when at least one bit of `rule_flags` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid on the observed channel |
| req_ready | input | 1 | Request ready on the observed channel (observed only) |
| req_addr | input | ADDR_W | Start address |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | Log2 of bytes per beat |
| req_burst | input | 2 | Burst type: 00 FIXED, 01 INCR, 10 WRAP, 11 reserved |
| req_lock | input | 1 | Exclusive access |
| req_cache | input | 4 | Memory attribute field |
| rule_flags | output | 10 | Sticky per-rule violation flags |
| any_error | output | 1 | OR of all flags |

## Verification
The bench targets the 4 KB edge from both sides. A burst ending exactly on byte 0xFFF must stay clean, and one reaching 0x1007 must flag. A design using the wrong end formula, for example LEN beats instead of LEN+1, would get one of these two cases wrong. The bench also sends WRAP and FIXED bursts whose naive end address crosses a page, so a monitor that applies the page check to every burst type raises false alarms there. Exclusive cases separate "not a power of two" from "power of two but misaligned", and a 256-byte exclusive burst exposes a missing 128-byte cap. Finally, the bench stalls a bad request with READY low and then presents bad attributes with VALID low, which catches flags that wait for the handshake or latch idle bus values.

// File: rtl/axi_brc_pkg.sv
package axi_brc_pkg;
  localparam int N_RULES        = 10;
  localparam int RULE_PAGE      = 0;
  localparam int RULE_WRAP_ALGN = 1;
  localparam int RULE_WRAP_LEN  = 2;
  localparam int RULE_TYPE_RSVD = 3;
  localparam int RULE_FIX_LEN   = 4;
  localparam int RULE_EXC_LEN   = 5;
  localparam int RULE_EXC_BYTES = 6;
  localparam int RULE_EXC_ALGN  = 7;
  localparam int RULE_OVERSIZE  = 8;
  localparam int RULE_CACHE     = 9;

  typedef logic [N_RULES-1:0] rule_vec_t;

  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_kind_e;

  localparam int BYTES_W = 16;  // (255+1) << 7 fits
endpackage

// File: rtl/axi_brc_geometry.sv
module axi_brc_geometry
  import axi_brc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         len,
  input  logic [2:0]         size,
  output logic [BYTES_W-1:0] total_bytes,
  output logic               page_cross,
  output logic               beat_misalign,
  output logic               total_misalign
);
  localparam int PAGE_BITS = 12;

  logic [8:0]        beats;
  logic [ADDR_W:0]   last_byte;
  logic [7:0]        beat_mask;

  always_comb begin
    beats       = {1'b0, len} + 9'd1;
    total_bytes = BYTES_W'(beats) << size;
    // last byte touched, one bit wider so wrap past the top counts as a cross
    last_byte   = {1'b0, addr} + (ADDR_W+1)'(total_bytes) - (ADDR_W+1)'(1);
    page_cross  = last_byte[ADDR_W:PAGE_BITS] != {1'b0, addr[ADDR_W-1:PAGE_BITS]};
    beat_mask   = (8'd1 << size) - 8'd1;
    beat_misalign  = (addr[7:0] & beat_mask) != 8'd0;
    total_misalign = (addr[BYTES_W-1:0] & (total_bytes - BYTES_W'(1))) != '0;
  end
endmodule

// File: rtl/axi_brc_rules.sv
module axi_brc_rules
  import axi_brc_pkg::*;
#(
  parameter int SIZE_MAX = 3
) (
  input  logic [7:0]         len,
  input  logic [2:0]         size,
  input  logic [1:0]         burst,
  input  logic               lock,
  input  logic [3:0]         cache,
  input  logic [BYTES_W-1:0] total_bytes,
  input  logic               page_cross,
  input  logic               beat_misalign,
  input  logic               total_misalign,
  output rule_vec_t          hits
);
  logic is_fixed, is_incr, is_wrap, pow2_total;

  always_comb begin
    is_fixed   = burst == BT_FIXED;
    is_incr    = burst == BT_INCR;
    is_wrap    = burst == BT_WRAP;
    pow2_total = (total_bytes & (total_bytes - BYTES_W'(1))) == '0;

    hits                 = '0;
    hits[RULE_PAGE]      = is_incr && page_cross;
    hits[RULE_WRAP_ALGN] = is_wrap && beat_misalign;
    hits[RULE_WRAP_LEN]  = is_wrap && !(len inside {8'd1, 8'd3, 8'd7, 8'd15});
    hits[RULE_TYPE_RSVD] = burst == BT_RSVD;
    hits[RULE_FIX_LEN]   = is_fixed && (len > 8'd15);
    hits[RULE_EXC_LEN]   = lock && (len > 8'd15);
    hits[RULE_EXC_BYTES] = lock && (!pow2_total || total_bytes > BYTES_W'(128));
    hits[RULE_EXC_ALGN]  = lock && pow2_total && total_misalign;
    hits[RULE_OVERSIZE]  = int'(size) > SIZE_MAX;
    hits[RULE_CACHE]     = !cache[1] && (cache[3:2] != 2'b00);
  end
endmodule

// File: rtl/axi_brc_sticky.sv
module axi_brc_sticky
  import axi_brc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sample_en,
  input  rule_vec_t hits,
  output rule_vec_t flags
);
  for (genvar i = 0; i < N_RULES; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  flags[i] <= 1'b0;
      else if (sample_en && hits[i]) flags[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/axi_burst_rule_monitor.sv
module axi_burst_rule_monitor
  import axi_brc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_len,
  input  logic [2:0]        req_size,
  input  logic [1:0]        req_burst,
  input  logic              req_lock,
  input  logic [3:0]        req_cache,
  output logic [9:0]        rule_flags,
  output logic              any_error
);
  localparam int BUS_BYTES = DATA_W / 8;
  localparam int SIZE_MAX  = $clog2(BUS_BYTES);

  logic [BYTES_W-1:0] total_bytes;
  logic               page_cross, beat_misalign, total_misalign;
  rule_vec_t          hits, flags;
  logic               sample_en;

  // sampled on handshake cycles and on stalled cycles alike
  assign sample_en = (req_valid & req_ready) | (req_valid & ~req_ready);

  axi_brc_geometry #(.ADDR_W(ADDR_W)) u_geom (
    .addr(req_addr), .len(req_len), .size(req_size),
    .total_bytes(total_bytes), .page_cross(page_cross),
    .beat_misalign(beat_misalign), .total_misalign(total_misalign)
  );

  axi_brc_rules #(.SIZE_MAX(SIZE_MAX)) u_rules (
    .len(req_len), .size(req_size), .burst(req_burst), .lock(req_lock),
    .cache(req_cache), .total_bytes(total_bytes), .page_cross(page_cross),
    .beat_misalign(beat_misalign), .total_misalign(total_misalign),
    .hits(hits)
  );

  axi_brc_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .hits(hits), .flags(flags)
  );

  assign rule_flags = flags;
  assign any_error  = |flags;
endmodule

// File: rtl/axi_burst_rule_monitor_chk.sv
module axi_burst_rule_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_len,
  input logic [2:0]        req_size,
  input logic [1:0]        req_burst,
  input logic [3:0]        req_cache,
  input logic [9:0]        rule_flags,
  input logic              any_error
);
  localparam int BUS_BYTES = DATA_W / 8;

  assert_page_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_burst == 2'b01 &&
     (17'(req_addr[11:0]) + ((17'(req_len) + 17'd1) << req_size)) > 17'd4096)
    |=> rule_flags[0]);

  assert_type_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_burst == 2'b11) |=> rule_flags[3]);

  assert_oversize_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (32'd1 << req_size) > 32'(BUS_BYTES)) |=> rule_flags[8]);

  assert_cache_rsvd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cache inside {4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1100, 4'b1101})
    |=> rule_flags[9]);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rule_flags & $past(rule_flags)) == $past(rule_flags)));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rule_flags));

  assert_err_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_error) |-> $past(req_valid));
endmodule

bind axi_burst_rule_monitor axi_burst_rule_monitor_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
  .req_cache(req_cache), .rule_flags(rule_flags), .any_error(any_error)
);

// File: tb/axi_burst_rule_monitor_test.sv
`timescale 1ns/1ps
module axi_burst_rule_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready = 1'b1, req_lock = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_burst = 2'b01;
  logic [3:0]  req_cache = 4'b0011;
  logic [9:0]  rule_flags;
  logic        any_error;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  axi_burst_rule_monitor #(.ADDR_W(32), .DATA_W(64)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
    .req_burst(req_burst), .req_lock(req_lock), .req_cache(req_cache),
    .rule_flags(rule_flags), .any_error(any_error)
  );

  task automatic check(string tag, logic [9:0] exp);
    checks++;
    if (rule_flags !== exp || any_error !== (|exp)) begin
      failures++;
      $display("FAIL %s: flags=%h err=%b expected flags=%h err=%b",
               tag, rule_flags, any_error, exp, |exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // present one request for `cycles` clocks, then drop valid; sample at negedge after
  task automatic drive(logic v, logic rdy, logic [31:0] a, logic [7:0] l, logic [2:0] s,
                       logic [1:0] b, logic lk, logic [3:0] c, int cycles);
    @(negedge clk);
    req_valid = v; req_ready = rdy; req_addr = a; req_len = l; req_size = s;
    req_burst = b; req_lock = lk; req_cache = c;
    for (int i = 0; i < cycles; i++) @(negedge clk);
    req_valid = 1'b0; req_ready = 1'b1; req_lock = 1'b0; req_cache = 4'b0011;
  endtask

  task automatic one(string tag, logic [31:0] a, logic [7:0] l, logic [2:0] s,
                     logic [1:0] b, logic lk, logic [3:0] c, logic [9:0] exp);
    do_reset();
    drive(1'b1, 1'b1, a, l, s, b, lk, c, 1);
    check(tag, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset state", 10'h000);
  endtask

  task automatic t_page();
    one("R2 incr legal",            32'h0000_1000, 8'd3,  3'd3, 2'b01, 1'b0, 4'b0011, 10'h000);
    one("R2 incr ends at 0xFFF",    32'h0000_0FF0, 8'd1,  3'd3, 2'b01, 1'b0, 4'b0011, 10'h000);
    one("R2 incr crosses",          32'h0000_0FF8, 8'd1,  3'd3, 2'b01, 1'b0, 4'b0011, 10'h001);
    one("R2 fixed exempt",          32'h0000_0FF8, 8'd15, 3'd3, 2'b00, 1'b0, 4'b0011, 10'h000);
    one("R2 wrap exempt",           32'h0000_0FFC, 8'd3,  3'd2, 2'b10, 1'b0, 4'b0011, 10'h000);
  endtask

  task automatic t_wrap();
    one("R3 wrap misaligned",       32'h0000_1002, 8'd3,  3'd2, 2'b10, 1'b0, 4'b0011, 10'h002);
    one("R4 wrap 3 beats",          32'h0000_1000, 8'd2,  3'd2, 2'b10, 1'b0, 4'b0011, 10'h004);
    one("R4 wrap 16 beats legal",   32'h0000_1000, 8'd15, 3'd2, 2'b10, 1'b0, 4'b0011, 10'h000);
  endtask

  task automatic t_type_fixed();
    one("R5 reserved type",         32'h0,         8'd0,  3'd0, 2'b11, 1'b0, 4'b0011, 10'h008);
    one("R6 fixed 17 beats",        32'h0,         8'd16, 3'd0, 2'b00, 1'b0, 4'b0011, 10'h010);
    one("R6 fixed 16 beats",        32'h0,         8'd15, 3'd0, 2'b00, 1'b0, 4'b0011, 10'h000);
  endtask

  task automatic t_excl();
    one("R7 R8 excl 17 bytes",      32'h0,         8'd16, 3'd0, 2'b01, 1'b1, 4'b0011, 10'h060);
    one("R7 R8 excl 256 bytes",     32'h0,         8'd31, 3'd3, 2'b01, 1'b1, 4'b0011, 10'h060);
    one("R8 excl 12 bytes",         32'h0,         8'd2,  3'd2, 2'b01, 1'b1, 4'b0011, 10'h040);
    one("R9 excl 128 misaligned",   32'h0000_0040, 8'd15, 3'd3, 2'b01, 1'b1, 4'b0011, 10'h080);
    one("R9 excl 128 aligned",      32'h0000_0080, 8'd15, 3'd3, 2'b01, 1'b1, 4'b0011, 10'h000);
  endtask

  task automatic t_size_cache();
    one("R10 size 16B on 8B bus",   32'h0,         8'd0,  3'd4, 2'b01, 1'b0, 4'b0011, 10'h100);
    one("R10 size 8B legal",        32'h0,         8'd0,  3'd3, 2'b01, 1'b0, 4'b0011, 10'h000);
    one("R11 cache 0100",           32'h0,         8'd0,  3'd0, 2'b01, 1'b0, 4'b0100, 10'h200);
    one("R11 cache 1010 legal",     32'h0,         8'd0,  3'd0, 2'b01, 1'b0, 4'b1010, 10'h000);
  endtask

  task automatic t_sticky();
    do_reset();
    drive(1'b1, 1'b0, 32'h0, 8'd0, 3'd0, 2'b11, 1'b0, 4'b0011, 1);
    check("R12 set while ready low", 10'h008);
    drive(1'b1, 1'b1, 32'h100, 8'd3, 3'd2, 2'b01, 1'b0, 4'b0011, 1);
    check("R12 held after legal req", 10'h008);
    drive(1'b0, 1'b1, 32'h0, 8'd0, 3'd4, 2'b01, 1'b0, 4'b0100, 2);
    check("R12 idle attributes ignored", 10'h008);
    drive(1'b1, 1'b0, 32'h0, 8'd0, 3'd4, 2'b01, 1'b0, 4'b0011, 3);
    check("R12 R13 stalled oversize adds", 10'h108);
  endtask

  initial begin
    t_reset();
    t_page();
    t_wrap();
    t_type_fixed();
    t_excl();
    t_size_cache();
    t_sticky();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule